// File: doc/BRIEF.md
# Two-Phase Clock Source Switch Sequencer

This block changes the setting of one clock channel without upsetting the logic that runs from it. A request carries a new source-select bit, a new divider code and a new shift code. The block never writes all three at once. It first writes a word that carries the new select bit but keeps the divider and shift from the last word it wrote. It then waits for one vertical sync interval so the clock tree can settle. Next it writes the complete new word, waits one more vertical sync interval, and only then reports completion.

The block keeps its own copy of the last word it wrote, so it can form the first-phase word without reading the register back. Requests enter through a valid/ready handshake. A request that arrives while a change is in progress is held off rather than lost. The busy output tells the surrounding bus logic to keep other transactions away while a change or a settle wait is running.

Each settle wait watches a vsync status input in two steps: it waits for vsync to be seen inactive, then for it to be seen active. Each step gives up after a bounded number of cycles, so a dead sync source cannot hang the sequence.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is asserted, and afterwards until a request is accepted, `busy` is 0, `req_ready` is 1, `cfg_wr_en` is 0 and `done` is 0.
- R2: The register word is laid out as {select (bit WORD_W-1), divider (next DIV_W bits), shift (low SHIFT_W bits)}. The first write of a request carries the requested select bit together with the divider and shift fields of the last word written. After reset, that last word is `RESET_WORD`.
- R3: The second write of a request carries the complete requested word, and this word becomes the held word for the next request.
- R4: Counting from the cycle after the first write, the block waits for vsync to be seen low in some cycle and then high in a later cycle. The second write occurs in the cycle after that high sample.
- R5: After the second write, the same low-then-high detection is applied. `done` is a single-cycle pulse in the cycle after the high sample, and in that cycle `busy` is already 0.
- R6: Each request produces exactly two write cycles, never in consecutive cycles, and `cfg_wr_en` is only asserted while `busy` is 1.
- R7: Each step of a settle wait gives up after TIMEOUT cycles. With vsync held constant, the second write comes TIMEOUT+2 cycles after the first, and `done` comes TIMEOUT+2 cycles after the second write.
- R8: `req_ready` is 1 exactly when the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and its first write occurs in the following cycle. A request held valid while the block is busy is stalled, not dropped.
- R9: A request already waiting is accepted in the same cycle that `done` pulses, so back-to-back changes lose no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A change request is offered |
| req_ready | output | 1 | The block can take a request |
| req_sel | input | 1 | Requested source-select bit |
| req_div | input | DIV_W | Requested divider code |
| req_shift | input | SHIFT_W | Requested shift code |
| vsync | input | 1 | Vertical sync status, 1 while active |
| cfg_wr_en | output | 1 | Write strobe to the clock-control register |
| cfg_wr_data | output | DIV_W+SHIFT_W+1 | Word to write |
| busy | output | 1 | A change or settle wait is running |
| done | output | 1 | One-cycle pulse when a request has fully completed |

## Verification
The hardest situation to reach is a settle wait that ends by timeout rather than by sync. It only happens when the sync source stops toggling. The stimulus covers it by holding vsync stuck high for one request and stuck low for another, which exercises both the inactive-step and active-step limits. A second hard case is a request that is queued behind a running change. The bench keeps `req_valid` asserted with new fields right after an acceptance, checks that it is never taken while busy, and checks that its first write comes in the cycle after the `done` pulse, carrying the divider and shift left by the previous request.

// File: rtl/clk_src_switch_pkg.sv
package clk_src_switch_pkg;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_SEL_WR,
        SW_SETTLE_A,
        SW_FULL_WR,
        SW_SETTLE_B
    } sw_state_e;

    typedef enum logic [1:0] {
        VW_OFF,
        VW_SEEK_LOW,
        VW_SEEK_HIGH
    } vw_phase_e;

endpackage

// File: rtl/clksw_vsync_wait.sv
module clksw_vsync_wait
    import clk_src_switch_pkg::*;
#(
    parameter int TIMEOUT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic vsync,
    output logic fin
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        vw_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } vw_regs_t;

    vw_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        fin = 1'b0;
        case (r_q.phase)
            VW_OFF: begin
                if (start) begin
                    r_d.phase = VW_SEEK_LOW;
                    r_d.cnt   = '0;
                end
            end
            VW_SEEK_LOW: begin
                if (!vsync || r_q.cnt == LIMIT) begin
                    r_d.phase = VW_SEEK_HIGH;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            VW_SEEK_HIGH: begin
                if (vsync || r_q.cnt == LIMIT) begin
                    fin       = 1'b1;
                    r_d.phase = VW_OFF;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.phase = VW_OFF;
                r_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase <= VW_OFF;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/clksw_word_build.sv
module clksw_word_build #(
    parameter int DIV_W   = 2,
    parameter int SHIFT_W = 3
) (
    input  logic [DIV_W+SHIFT_W:0] held_word,
    input  logic                   new_sel,
    input  logic [DIV_W-1:0]       new_div,
    input  logic [SHIFT_W-1:0]     new_shift,
    input  logic                   full,
    output logic [DIV_W+SHIFT_W:0] word
);
    localparam int LOW_W = DIV_W + SHIFT_W;

    logic [LOW_W-1:0] low_part;

    always_comb begin
        if (full) begin
            low_part = {new_div, new_shift};
        end else begin
            low_part = held_word[LOW_W-1:0];
        end
        word = {new_sel, low_part};
    end

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clk_src_switch_pkg::*;
#(
    parameter int DIV_W   = 2,
    parameter int SHIFT_W = 3,
    parameter int TIMEOUT = 10000,
    parameter logic [DIV_W+SHIFT_W:0] RESET_WORD = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_sel,
    input  logic [DIV_W-1:0]       req_div,
    input  logic [SHIFT_W-1:0]     req_shift,
    input  logic                   vsync,
    output logic                   cfg_wr_en,
    output logic [DIV_W+SHIFT_W:0] cfg_wr_data,
    output logic                   busy,
    output logic                   done
);
    localparam int WORD_W = DIV_W + SHIFT_W + 1;

    typedef struct packed {
        sw_state_e          state;
        logic               sel;
        logic [DIV_W-1:0]   div;
        logic [SHIFT_W-1:0] shift;
        logic [WORD_W-1:0]  held;
        logic               done;
    } sw_regs_t;

    sw_regs_t r_q, r_d;

    logic              wait_start;
    logic              wait_fin;
    logic              full_phase;
    logic [WORD_W-1:0] built_word;

    assign full_phase = (r_q.state == SW_FULL_WR);

    clksw_word_build #(
        .DIV_W   (DIV_W),
        .SHIFT_W (SHIFT_W)
    ) u_build (
        .held_word (r_q.held),
        .new_sel   (r_q.sel),
        .new_div   (r_q.div),
        .new_shift (r_q.shift),
        .full      (full_phase),
        .word      (built_word)
    );

    clksw_vsync_wait #(
        .TIMEOUT (TIMEOUT)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wait_start),
        .vsync (vsync),
        .fin   (wait_fin)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        cfg_wr_en  = 1'b0;
        wait_start = 1'b0;
        case (r_q.state)
            SW_IDLE: begin
                if (req_valid) begin
                    r_d.sel   = req_sel;
                    r_d.div   = req_div;
                    r_d.shift = req_shift;
                    r_d.state = SW_SEL_WR;
                end
            end
            SW_SEL_WR: begin
                cfg_wr_en  = 1'b1;
                wait_start = 1'b1;
                r_d.held   = built_word;
                r_d.state  = SW_SETTLE_A;
            end
            SW_SETTLE_A: begin
                if (wait_fin) begin
                    r_d.state = SW_FULL_WR;
                end
            end
            SW_FULL_WR: begin
                cfg_wr_en  = 1'b1;
                wait_start = 1'b1;
                r_d.held   = built_word;
                r_d.state  = SW_SETTLE_B;
            end
            SW_SETTLE_B: begin
                if (wait_fin) begin
                    r_d.done  = 1'b1;
                    r_d.state = SW_IDLE;
                end
            end
            default: begin
                r_d.state = SW_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= SW_IDLE;
            r_q.sel   <= 1'b0;
            r_q.div   <= '0;
            r_q.shift <= '0;
            r_q.held  <= RESET_WORD;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_wr_data = built_word;
    assign req_ready   = (r_q.state == SW_IDLE);
    assign busy        = (r_q.state != SW_IDLE);
    assign done        = r_q.done;

endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk #(
    parameter int WORD_W  = 6,
    parameter int TIMEOUT = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_sel,
    input logic              cfg_wr_en,
    input logic [WORD_W-1:0] cfg_wr_data,
    input logic              busy,
    input logic              done
);
    int gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (cfg_wr_en || !busy) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    // R6
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> busy);

    // R6
    wr_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> !cfg_wr_en);

    // R8
    accept_then_sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cfg_wr_en && (cfg_wr_data[WORD_W-1] == $past(req_sel))));

    // R5
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !busy));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 2 * TIMEOUT);

endmodule

bind clk_src_switch clk_src_switch_chk #(
    .WORD_W  (WORD_W),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_sel     (req_sel),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .busy        (busy),
    .done        (done)
);

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/1ps
module sim_clk_src_switch;
    localparam int DIV_W   = 2;
    localparam int SHIFT_W = 3;
    localparam int WORD_W  = DIV_W + SHIFT_W + 1;
    localparam int TO      = 20;
    localparam logic [WORD_W-1:0] RST_WORD = 6'h15;

    // {sel, div[1:0], shift[2:0], period[7:0], high[7:0]}
    localparam int NVEC = 4;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 2'b01, 3'b011, 8'd12, 8'd4},
        {1'b0, 2'b11, 3'b111, 8'd8,  8'd2},
        {1'b1, 2'b00, 3'b000, 8'd15, 8'd7},
        {1'b1, 2'b10, 3'b110, 8'd10, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_sel = 1'b0;
    logic [DIV_W-1:0] req_div = '0;
    logic [SHIFT_W-1:0] req_shift = '0;
    logic vsync = 1'b0;
    logic cfg_wr_en;
    logic [WORD_W-1:0] cfg_wr_data;
    logic busy;
    logic done;

    always #10 clk = ~clk;

    clk_src_switch #(
        .DIV_W      (DIV_W),
        .SHIFT_W    (SHIFT_W),
        .TIMEOUT    (TO),
        .RESET_WORD (RST_WORD)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_sel     (req_sel),
        .req_div     (req_div),
        .req_shift   (req_shift),
        .vsync       (vsync),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .busy        (busy),
        .done        (done)
    );

    int tests = 0;
    int fails = 0;

    // vsync source: 0 periodic, 1 stuck high, 2 stuck low
    int vs_mode = 0;
    int vs_period = 12;
    int vs_high = 4;
    int vs_ph = 0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (vs_mode == 1) vsync = 1'b1;
            else if (vs_mode == 2) vsync = 1'b0;
            else begin
                vs_ph = (vs_ph + 1 >= vs_period) ? 0 : vs_ph + 1;
                vsync = (vs_ph < vs_high);
            end
        end
    end

    // port monitor and sync-detection expectation
    int cyc = 0;
    int nwr = 0;
    int ndone = 0;
    int wr_cyc [64];
    logic [WORD_W-1:0] wr_dat [64];
    int fin_cyc [64];
    int done_cyc [32];
    bit tr_arm = 0;
    bit tr_low = 0;
    int tr_idx = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (tr_arm) begin
                if (!vsync) tr_low = 1;
                else if (tr_low) begin
                    fin_cyc[tr_idx] = cyc;
                    tr_arm = 0;
                end
            end
            if (cfg_wr_en && nwr < 64) begin
                wr_cyc[nwr] = cyc;
                wr_dat[nwr] = cfg_wr_data;
                fin_cyc[nwr] = -1;
                tr_arm = 1;
                tr_low = 0;
                tr_idx = nwr;
                nwr = nwr + 1;
            end
            if (done && ndone < 32) begin
                done_cyc[ndone] = cyc;
                ndone = ndone + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(input int bd);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (ndone > bd) break;
        end
    endtask

    logic [WORD_W-1:0] held = RST_WORD;

    task automatic run_txn(input logic s, input logic [DIV_W-1:0] d,
                           input logic [SHIFT_W-1:0] sh, input bit stuck);
        int base;
        int bd;
        int acc;
        logic [WORD_W-1:0] e1;
        logic [WORD_W-1:0] e2;
        base = nwr;
        bd = ndone;
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_sel = s;
        req_div = d;
        req_shift = sh;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (req_ready) break;
        end
        acc = cyc;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        wait_done(bd);
        e1 = {s, held[WORD_W-2:0]};
        e2 = {s, d, sh};
        // R8: first write in the cycle after acceptance
        chk(wr_cyc[base] == acc + 1, "R8 first write cycle", wr_cyc[base], acc + 1);
        // R2: select-only word
        chk(wr_dat[base] == e1, "R2 phase-one word", wr_dat[base], e1);
        // R3: full word
        chk(wr_dat[base + 1] == e2, "R3 phase-two word", wr_dat[base + 1], e2);
        // R6: exactly two writes
        chk(nwr == base + 2, "R6 write count", nwr - base, 2);
        if (stuck) begin
            // R7: timeout-bounded waits
            chk(wr_cyc[base + 1] == wr_cyc[base] + TO + 2, "R7 second write after timeout",
                wr_cyc[base + 1], wr_cyc[base] + TO + 2);
            chk(done_cyc[bd] == wr_cyc[base + 1] + TO + 2, "R7 done after timeout",
                done_cyc[bd], wr_cyc[base + 1] + TO + 2);
        end else begin
            // R4: second write after low-then-high vsync
            chk(wr_cyc[base + 1] == fin_cyc[base] + 1, "R4 second write cycle",
                wr_cyc[base + 1], fin_cyc[base] + 1);
            // R5: done after second settle
            chk(done_cyc[bd] == fin_cyc[base + 1] + 1, "R5 done cycle",
                done_cyc[bd], fin_cyc[base + 1] + 1);
        end
        held = e2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(cfg_wr_en == 1'b0, "R1 wr_en in reset", cfg_wr_en, 0);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(busy == 1'b0 && req_ready == 1'b1 && cfg_wr_en == 1'b0, "R1 idle after reset",
            {busy, req_ready, cfg_wr_en}, 3'b010);
        chk(nwr == 0, "R1 no write before request", nwr, 0);

        for (int v = 0; v < NVEC; v++) begin
            vs_period = int'(VEC[v][15:8]);
            vs_high = int'(VEC[v][7:0]);
            vs_ph = 0;
            run_txn(VEC[v][21], VEC[v][20:19], VEC[v][18:16], 1'b0);
        end

        // R7: vsync stuck high, then stuck low
        vs_mode = 1;
        run_txn(1'b0, 2'b01, 3'b001, 1'b1);
        vs_mode = 2;
        run_txn(1'b1, 2'b11, 3'b010, 1'b1);

        // R8, R9: request queued behind a running change
        vs_mode = 0;
        vs_period = 9;
        vs_high = 3;
        begin
            int base;
            int bd;
            int stall_bad;
            logic [WORD_W-1:0] held_a;
            base = nwr;
            bd = ndone;
            stall_bad = 0;
            @(posedge clk);
            #2;
            req_valid = 1'b1;
            req_sel = 1'b0;
            req_div = 2'b10;
            req_shift = 3'b100;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                #1;
                if (req_ready) break;
            end
            @(posedge clk);
            #2;
            req_sel = 1'b1;
            req_div = 2'b01;
            req_shift = 3'b111;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                #1;
                if (ndone > bd) break;
                if (req_ready) stall_bad = stall_bad + 1;
            end
            // R8: stalled while busy
            chk(stall_bad == 0, "R8 ready while busy", stall_bad, 0);
            chk(req_ready == 1'b1, "R8 ready at done", req_ready, 1);
            @(posedge clk);
            #2;
            req_valid = 1'b0;
            wait_done(bd + 1);
            held_a = 6'b0_10_100;
            // R9: accepted in the done cycle
            chk(wr_cyc[base + 2] == done_cyc[bd] + 1, "R9 back-to-back first write",
                wr_cyc[base + 2], done_cyc[bd] + 1);
            // R8: queued request not dropped, R2 uses previous word
            chk(wr_dat[base + 2] == {1'b1, held_a[WORD_W-2:0]}, "R2 queued phase-one word",
                wr_dat[base + 2], {1'b1, held_a[WORD_W-2:0]});
            chk(wr_dat[base + 3] == 6'b1_01_111, "R3 queued phase-two word",
                wr_dat[base + 3], 6'b1_01_111);
            chk(nwr == base + 4, "R6 write count for pair", nwr - base, 4);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule